// File: doc/BRIEF.md
# Transmit Preamble and Header Sequencer

This block steps one transmit packet through its fields. A packet starts with a preamble and a start-frame delimiter. A 2-bit mode picks which header fields follow. The data phase comes last and lasts until a stop input arrives. The sequencer advances one bit on each transmit bit-clock enable. When the constant-rate option is set, every preamble and header bit takes two enables, because the preamble and header are always sent as DBPSK while the bit clock runs at the QPSK rate.

A ready output tells the data source that the data phase is near. It rises when the bit-clock ticks left in the header are no more than a programmable 5-bit lead count. If the lead count is larger than the whole header, ready rises at the first header bit. If the lead count is zero, ready rises on the first data cycle. A per-symbol flag shows when the data symbols are QPSK. Mode, modulation select, lead count and rate option are all captured when the packet starts.

Top module: `tx_hdr_seq`

## Requirements
- R1: After synchronous reset, `phase_o` is 0 (idle), and `ready_o` and `sym_qpsk_o` are 0.
- R2: A `start_i` pulse in idle makes `phase_o` equal 1 (preamble) on the next cycle. Fields advance only on cycles where `bit_en_i` is high.
- R3: Phase codes are idle 0, preamble 1, delimiter 2, signal 3, service 4, length 5, CRC 6, data 7. After the delimiter, the fields follow the mode captured at start:
  - mode 00: data
  - mode 01: CRC, then data
  - mode 10: length, CRC, then data
  - mode 11: signal, service, length, CRC, then data
- R4: Field lengths in bits are: preamble 128, delimiter 16, signal 8, service 8, length 16, CRC 16.
- R5: With the constant-rate option captured as 1, each preamble and header bit lasts two `bit_en_i` ticks. With the option at 0, each bit lasts one tick.
- R6: The header is every field from the delimiter through CRC. During the header, `ready_o` is 1 exactly when the header ticks still to be sent are no more than the lead count N. Once high, `ready_o` stays high through the whole data phase. With N = 0, `ready_o` first rises on the first data cycle.
- R7: When N is at least the number of header ticks, `ready_o` is 1 from the first delimiter cycle. It is always 0 during the preamble.
- R8: `sym_qpsk_o` is 1 only in the data phase, and only when the captured mode is not 00 and the captured modulation select is 1.
- R9: `stop_i` in the data phase returns `phase_o` to idle on the next cycle. `stop_i` has no effect in any other phase.
- R10: `start_i` has no effect while a packet is in progress.
- R11: Changes to the mode, modulation select, lead count or rate option after start do not affect the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Packet start pulse |
| stop_i | input | 1 | Ends the data phase |
| bit_en_i | input | 1 | Transmit bit-clock enable |
| mode_i | input | 2 | Header field-set select |
| qpsk_i | input | 1 | Data modulation: 1 selects QPSK |
| lead_i | input | 5 | Ready lead count N |
| const_rate_i | input | 1 | Double-clocks preamble and header bits |
| phase_o | output | 3 | Current phase code |
| ready_o | output | 1 | Data-ready strobe level |
| sym_qpsk_o | output | 1 | Current symbol is QPSK |

## Verification
The bench targets the ready edge at each end of its range. With a lead count of zero, a design that fires one tick early would raise ready during the last CRC bit. With a lead count above the mode-00 header length, a design that does not clamp would wrap or keep ready low through the delimiter. Constant-rate packets driven by irregular enables expose a design that counts cycles instead of ticks, or that double-clocks only part of the header. Stray start and stop pulses and configuration changes in mid-packet catch a design that restarts, exits early, or reads live inputs instead of captured ones. A mode-00 packet with QPSK selected must still show a DBPSK data flag.

// File: rtl/tx_hdr_seq_pkg.sv
package tx_hdr_seq_pkg;

    localparam int PRE_BITS = 128;
    localparam int SFD_BITS = 16;
    localparam int SIG_BITS = 8;
    localparam int SRV_BITS = 8;
    localparam int LEN_BITS = 16;
    localparam int CRC_BITS = 16;
    localparam int CNT_W    = $clog2(PRE_BITS + 1);
    localparam int HDR_W    = $clog2(2 * (SFD_BITS + SIG_BITS + SRV_BITS + LEN_BITS + CRC_BITS) + 1);

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_SFD  = 3'd2,
        PH_SIG  = 3'd3,
        PH_SRV  = 3'd4,
        PH_LEN  = 3'd5,
        PH_CRC  = 3'd6,
        PH_DATA = 3'd7
    } phase_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       qpsk;
        logic [4:0] lead;
        logic       dbl;
    } pkt_cfg_t;

    function automatic logic [CNT_W-1:0] field_len(phase_e ph);
        case (ph)
            PH_PRE:  return CNT_W'(PRE_BITS);
            PH_SFD:  return CNT_W'(SFD_BITS);
            PH_SIG:  return CNT_W'(SIG_BITS);
            PH_SRV:  return CNT_W'(SRV_BITS);
            PH_LEN:  return CNT_W'(LEN_BITS);
            PH_CRC:  return CNT_W'(CRC_BITS);
            default: return CNT_W'(1);
        endcase
    endfunction

    function automatic phase_e next_field(phase_e ph, logic [1:0] mode);
        case (ph)
            PH_PRE:  return PH_SFD;
            PH_SFD: begin
                case (mode)
                    2'b00:   return PH_DATA;
                    2'b01:   return PH_CRC;
                    2'b10:   return PH_LEN;
                    default: return PH_SIG;
                endcase
            end
            PH_SIG:  return PH_SRV;
            PH_SRV:  return PH_LEN;
            PH_LEN:  return PH_CRC;
            PH_CRC:  return PH_DATA;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic logic [HDR_W-1:0] hdr_ticks(logic [1:0] mode, logic dbl);
        logic [HDR_W-1:0] bits;
        case (mode)
            2'b00:   bits = HDR_W'(SFD_BITS);
            2'b01:   bits = HDR_W'(SFD_BITS + CRC_BITS);
            2'b10:   bits = HDR_W'(SFD_BITS + LEN_BITS + CRC_BITS);
            default: bits = HDR_W'(SFD_BITS + SIG_BITS + SRV_BITS + LEN_BITS + CRC_BITS);
        endcase
        return dbl ? (bits << 1) : bits;
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic          dbl,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt_q;
    logic          half_q;

    assign done = tick && (!dbl || half_q) && (cnt_q == len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr || done) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (tick) begin
            if (dbl && !half_q) begin
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                cnt_q  <= cnt_q + CW'(1);
            end
        end
    end

    AST_CNT_IN_FIELD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < len)); // R4
    AST_HALF_ONLY_DBL: assert property (@(posedge clk) disable iff (rst)
        (half_q && !clr) |-> dbl); // R5
endmodule

// File: rtl/tx_lead_ctrl.sv
module tx_lead_ctrl #(
    parameter int HW = 8,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [HW-1:0] load_val,
    input  logic          dec,
    input  logic          in_hdr,
    input  logic          in_data,
    input  logic [LW-1:0] lead,
    output logic          ready
);
    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - HW'(1);
        end
    end

    assign ready = in_data || (in_hdr && (left_q <= HW'(lead)));

    AST_LEFT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        dec |-> (left_q != '0)); // R6
endmodule

// File: rtl/tx_hdr_seq.sv
module tx_hdr_seq
    import tx_hdr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       bit_en_i,
    input  logic [1:0] mode_i,
    input  logic       qpsk_i,
    input  logic [4:0] lead_i,
    input  logic       const_rate_i,
    output logic [2:0] phase_o,
    output logic       ready_o,
    output logic       sym_qpsk_o
);
    phase_e   phase_q;
    pkt_cfg_t cfg_q;
    logic     in_hdr;
    logic     in_bits;
    logic     field_done;
    logic     launch;

    assign launch  = (phase_q == PH_IDLE) && start_i;
    assign in_hdr  = (phase_q >= PH_SFD) && (phase_q <= PH_CRC);
    assign in_bits = (phase_q == PH_PRE) || in_hdr;

    tx_bit_timer #(.CW(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (!in_bits),
        .tick (bit_en_i && in_bits),
        .dbl  (cfg_q.dbl),
        .len  (field_len(phase_q)),
        .done (field_done)
    );

    tx_lead_ctrl #(.HW(HDR_W), .LW(5)) u_lead (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (hdr_ticks(mode_i, const_rate_i)),
        .dec      (bit_en_i && in_hdr),
        .in_hdr   (in_hdr),
        .in_data  (phase_q == PH_DATA),
        .lead     (cfg_q.lead),
        .ready    (ready_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_PRE;
                        cfg_q   <= '{mode: mode_i, qpsk: qpsk_i, lead: lead_i, dbl: const_rate_i};
                    end
                end
                PH_DATA: begin
                    if (stop_i) phase_q <= PH_IDLE;
                end
                default: begin
                    if (field_done) phase_q <= next_field(phase_q, cfg_q.mode);
                end
            endcase
        end
    end

    assign phase_o    = phase_q;
    assign sym_qpsk_o = (phase_q == PH_DATA) && cfg_q.qpsk && (cfg_q.mode != 2'b00);

    AST_START_TO_PRE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start_i) |=> (phase_q == PH_PRE)); // R2
    AST_MODE0_SKIP: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SFD && cfg_q.mode == 2'b00) |=> (phase_q == PH_SFD || phase_q == PH_DATA)); // R3
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
        (ready_o && phase_q != PH_DATA) |=> ready_o); // R6
    AST_NO_READY_PRE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PRE) |-> !ready_o); // R7
    AST_STOP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && stop_i) |=> (phase_q == PH_IDLE)); // R9
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && !stop_i) |=> (phase_q == PH_DATA)); // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> $stable(cfg_q)); // R11
endmodule

// File: tb/sim_tx_hdr_seq.sv
module sim_tx_hdr_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, stop_i = 1'b0, bit_en_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       qpsk_i = 1'b0;
    logic [4:0] lead_i = 5'd0;
    logic       const_rate_i = 1'b0;
    logic [2:0] phase_o;
    logic       ready_o, sym_qpsk_o;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    string cur_req = "R1";
    int pat = 0;
    logic [31:0] seed = 32'h1234_5678;

    // reference model state
    int m_ph = 0, m_cnt = 0, m_half = 0, m_hrem = 0;
    int mm = 0, mq = 0, mn = 0, mc = 0;
    int fq[$];

    always #4 clk = ~clk;

    tx_hdr_seq u0 (.*);

    function automatic int flen(int ph);
        case (ph)
            1: return 128;
            2: return 16;
            3: return 8;
            4: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic model_update();
        if (m_ph == 0) begin
            if (start_i) begin
                mm = int'(mode_i); mq = int'(qpsk_i); mn = int'(lead_i); mc = int'(const_rate_i);
                fq.delete();
                fq.push_back(2);
                if (mm == 3) begin fq.push_back(3); fq.push_back(4); end
                if (mm >= 2) fq.push_back(5);
                if (mm >= 1) fq.push_back(6);
                fq.push_back(7);
                m_hrem = 0;
                foreach (fq[i]) if (fq[i] != 7) m_hrem += flen(fq[i]);
                if (mc != 0) m_hrem *= 2;
                m_ph = 1; m_cnt = 128; m_half = 0;
            end
        end else if (m_ph == 7) begin
            if (stop_i) m_ph = 0;
        end else if (bit_en_i) begin
            if (m_ph >= 2) m_hrem--;
            if (mc != 0 && m_half == 0) begin
                m_half = 1;
            end else begin
                m_half = 0;
                m_cnt--;
                if (m_cnt == 0) begin
                    m_ph = fq.pop_front();
                    if (m_ph != 7) m_cnt = flen(m_ph);
                end
            end
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    task automatic compare();
        int e_rdy, e_sym;
        e_rdy = (m_ph == 7 || (m_ph >= 2 && m_ph <= 6 && m_hrem <= mn)) ? 1 : 0;
        e_sym = (m_ph == 7 && mm != 0 && mq != 0) ? 1 : 0;
        check(cur_req, "phase", int'(phase_o), m_ph);
        check((cur_req == "R7") ? "R7" : "R6", "ready", int'(ready_o), e_rdy);
        check("R8", "sym_qpsk", int'(sym_qpsk_o), e_sym);
    endtask

    task automatic tick();
        case (pat)
            0: bit_en_i = 1'b1;
            1: bit_en_i = cycles[0];
            default: begin
                seed = seed * 32'd1103515245 + 32'd12345;
                bit_en_i = seed[17] | seed[9];
            end
        endcase
        model_update();
        @(posedge clk);
        cycles++;
        @(negedge clk);
        compare();
        start_i = 1'b0;
        stop_i  = 1'b0;
    endtask

    task automatic run_pkt(int m, int q, int n, int c, int p, int dcyc, string req, bit stray);
        int guard;
        cur_req = req; pat = p;
        mode_i = 2'(m); qpsk_i = 1'(q); lead_i = 5'(n); const_rate_i = 1'(c);
        start_i = 1'b1;
        tick();
        check("R2", "phase after start", int'(phase_o), 1);
        guard = 0;
        while (m_ph != 7 && guard < 5000) begin
            if (stray && guard == 40) start_i = 1'b1;   // R10
            if (stray && guard == 50) stop_i = 1'b1;    // R9 ignored outside data
            if (stray && guard == 60) begin             // R11
                mode_i = ~mode_i; qpsk_i = ~qpsk_i; lead_i = ~lead_i; const_rate_i = ~const_rate_i;
            end
            if (stray && m_ph == 6 && guard % 3 == 0) start_i = 1'b1;
            tick();
            guard++;
        end
        check(req, "reached data", m_ph, 7);
        for (int i = 0; i < dcyc; i++) begin
            if (stray && i == 2) start_i = 1'b1;        // R10 in data
            tick();
        end
        stop_i = 1'b1;
        tick();
        check("R9", "idle after stop", int'(phase_o), 0);
        tick();
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "reset phase", int'(phase_o), 0);
        check("R1", "reset ready", int'(ready_o), 0);
        check("R1", "reset sym", int'(sym_qpsk_o), 0);
        tick();
        run_pkt(0, 0, 0, 0, 0, 4, "R2", 0);
        run_pkt(3, 0, 5, 0, 0, 5, "R3", 0);
        run_pkt(2, 1, 31, 0, 0, 3, "R4", 0);
        run_pkt(1, 1, 0, 1, 2, 6, "R5", 0);
        run_pkt(3, 1, 31, 1, 1, 4, "R6", 0);
        run_pkt(0, 1, 20, 0, 1, 3, "R7", 0);
        run_pkt(0, 0, 31, 1, 2, 3, "R7", 0);
        run_pkt(1, 0, 3, 0, 2, 5, "R10", 1);
        run_pkt(2, 1, 0, 1, 0, 4, "R11", 1);
        run_pkt(3, 1, 16, 0, 2, 5, "R9", 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule